// File: doc/BRIEF.md
# Serial-Load Register with Held Parallel Outputs

This block takes a serial bit stream and shifts it through a chain of stages. On command, it copies the whole chain into a separate holding register that drives a three-state parallel bus. Shifting and transfer are two independent enables in the same clock domain. Each enable stands for one rising edge of a serial-port clock or of a select line, which logic outside the block detects. Because the enables are separate, a new word can be shifted in while the previous word stays on the bus, and the bus switches in one step when the transfer is issued.

The last stage drives a serial output that has no high-impedance state. Several units can therefore be cascaded, with each unit's serial output feeding the next unit's serial input and all units sharing both enables. An active-low asynchronous clear resets only the shift stages. The holding register has no reset at all, so it can be cleared only by transferring a cleared chain. An active-low output enable floats the parallel bus and leaves the serial output driven.

Top module: `sipo_latch_reg`

## Requirements
- R1: On a clock edge with `shift_en` high, stage 0 takes `ser_in` and every stage k takes the old value of stage k-1, all in the same edge.
- R2: `ser_out` always shows the last stage (stage DEPTH-1), including when `oe_n` is high.
- R3: On a clock edge with `latch_en` high, all stages are copied into the holding register; with `latch_en` low, the holding register keeps its value.
- R4: Driving `rst_n` low clears every shift stage to 0 at once, without waiting for a clock edge; the holding register is not changed by it.
- R5: With `oe_n` low, `par_q[k]` equals holding-register bit k; with `oe_n` high, every bit of `par_q` is high impedance.
- R6: On an edge with `shift_en` low, the shift stages keep their value whatever `ser_in` does.
- R7: When `shift_en` and `latch_en` are high on the same edge, the holding register receives the stage contents from before that shift.
- R8: Bit k of `par_q` comes from stage k, so the first of DEPTH bits shifted in appears on `par_q[DEPTH-1]`, and a word sent most-significant bit first appears unchanged on `par_q`.
- R9: Two units chained through `ser_out` to `ser_in`, sharing both enables, hold the last DEPTH bits of a 2*DEPTH-bit stream in the first unit and the first DEPTH bits in the second unit.
- R10: After `rst_n` rises, the stages stay cleared for the next RST_SYNC (default 2) clock edges, even if `shift_en` is high; the first shift is accepted on the edge after those.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low clear of the shift stages, asserted asynchronously and released synchronously |
| ser_in | input | 1 | Serial data into stage 0 |
| shift_en | input | 1 | Shift strobe, one cycle for each serial clock edge |
| latch_en | input | 1 | Transfer strobe from the stages to the holding register |
| oe_n | input | 1 | Active-low enable of the parallel bus |
| par_q | output | DEPTH | Three-state parallel outputs from the holding register |
| ser_out | output | 1 | Last stage, used for cascading |

## Verification
If a shift stage is corrupted, the error reaches `ser_out` after as many shifts as there are stages between that stage and the end of the chain. It reaches `par_q` one edge after the next transfer. A corrupted holding register shows on the bus at once, but only while `oe_n` is low. A wrong bit order or a lost same-edge ordering shows as a one-bit skew of the whole bus. The random phase therefore checks both outputs after every cycle and toggles the output enable at random.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // Fewest release-synchronizer stages that still give a clean release edge.
  localparam int unsigned RST_SYNC_MIN = 2;
  // Fewest shift stages the checker's stage-to-stage properties need.
  localparam int unsigned DEPTH_MIN    = 2;
endpackage

// File: rtl/sipo_rst_sync.sv
module sipo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [DEPTH-1:0] stages
);
  logic [DEPTH-1:0] stages_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb stages_d[g] = shift_en ? ser_in : stages[g];
    end else begin : g_body
      always_comb stages_d[g] = shift_en ? stages[g-1] : stages[g];
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) stages <= '0;
    else        stages <= stages_d;
  end
endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             load_en,
  input  logic [DEPTH-1:0] d,
  output logic [DEPTH-1:0] q
);
  logic [DEPTH-1:0] q_d;

  always_comb begin
    q_d = load_en ? d : q;
  end

  // No reset on purpose: cleared only by transferring a cleared chain.
  always_ff @(posedge clk) begin
    q <= q_d;
  end
endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg
  import sipo_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned RST_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             shift_en,
  input  logic             latch_en,
  input  logic             oe_n,
  output logic [DEPTH-1:0] par_q,
  output logic             ser_out
);
  localparam int unsigned SYNC_N = (RST_SYNC < RST_SYNC_MIN) ? RST_SYNC_MIN : RST_SYNC;

  logic             rst_int_n;
  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] st_q;

  sipo_rst_sync #(.STAGES(SYNC_N)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  sipo_shift_chain #(.DEPTH(DEPTH)) u_chain (
    .clk      (clk),
    .clr_n    (rst_int_n),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .stages   (sr_q)
  );

  sipo_hold_reg #(.DEPTH(DEPTH)) u_hold (
    .clk     (clk),
    .load_en (latch_en),
    .d       (sr_q),
    .q       (st_q)
  );

  assign ser_out = sr_q[DEPTH-1];
  assign par_q   = oe_n ? {DEPTH{1'bz}} : st_q;
endmodule

// File: rtl/sipo_latch_reg_chk.sv
module sipo_latch_reg_chk #(
  parameter int unsigned DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_int_n,
  input logic             ser_in,
  input logic             shift_en,
  input logic             latch_en,
  input logic             ser_out,
  input logic [DEPTH-1:0] sr_q,
  input logic [DEPTH-1:0] st_q
);
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_int_n)
    shift_en |=> sr_q[0] == $past(ser_in)); // R1
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    shift_en |=> sr_q[DEPTH-1:1] == $past(sr_q[DEPTH-2:0])); // R1
  AST_SEROUT_NEXT: assert property (@(posedge clk) disable iff (!rst_int_n)
    shift_en |=> ser_out == $past(sr_q[DEPTH-2])); // R2
  AST_STORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> st_q == $past(sr_q)); // R3
  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(st_q)); // R3
  AST_SR_CLEAR: assert property (@(posedge clk)
    !rst_n |-> sr_q == '0); // R4
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !shift_en |=> $stable(sr_q)); // R6
  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (shift_en && latch_en) |=> st_q == $past(sr_q)); // R7
  AST_REL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |=> sr_q == '0); // R10
endmodule

bind sipo_latch_reg sipo_latch_reg_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_int_n (rst_int_n),
  .ser_in    (ser_in),
  .shift_en  (shift_en),
  .latch_en  (latch_en),
  .ser_out   (ser_out),
  .sr_q      (sr_q),
  .st_q      (st_q)
);

// File: tb/sipo_latch_reg_bench.sv
module sipo_latch_reg_bench;
  localparam int D = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ser_in, shift_en, latch_en, oe_n;
  wire [D-1:0] bus_a;
  wire [D-1:0] bus_b;
  wire         link;
  wire         ser_b;

  for (genvar i = 0; i < D; i++) begin : g_pu
    pullup (bus_a[i]);
    pullup (bus_b[i]);
  end

  sipo_latch_reg #(.DEPTH(D)) u_sipo_latch_reg (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_en(shift_en),
    .latch_en(latch_en), .oe_n(oe_n), .par_q(bus_a), .ser_out(link)
  );

  sipo_latch_reg #(.DEPTH(D)) u_sipo_latch_reg_nxt (
    .clk(clk), .rst_n(rst_n), .ser_in(link), .shift_en(shift_en),
    .latch_en(latch_en), .oe_n(oe_n), .par_q(bus_b), .ser_out(ser_b)
  );

  int checks = 0;
  int errors = 0;
  logic [D-1:0] exp_sr, exp_st;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [D-1:0] bus_exp(input logic oe_bar, input logic [D-1:0] st);
    return oe_bar ? {D{1'b1}} : st;
  endfunction

  task automatic step(input logic sh, input logic si, input logic la);
    @(negedge clk);
    shift_en = sh; ser_in = si; latch_en = la;
    @(posedge clk);
    if (la) exp_st = exp_sr;
    if (sh) exp_sr = {exp_sr[D-2:0], si};
    #1;
    shift_en = 1'b0; latch_en = 1'b0;
  endtask

  task automatic load_word(input logic [D-1:0] w);
    for (int i = D - 1; i >= 0; i--) step(1'b1, w[i], 1'b0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] chain_w;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ser_in = 1'b0; shift_en = 1'b0; latch_en = 1'b0; oe_n = 1'b0;
    exp_sr = '0; exp_st = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(link == 1'b0, "R4 reset state ser_out", 32'(link), 0);

    // R10: release with shifting requested on the first two edges
    @(negedge clk);
    rst_n = 1'b1; shift_en = 1'b1; ser_in = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    shift_en = 1'b0;
    exp_sr = '0;
    step(1'b0, 1'b0, 1'b1);
    #1 chk(bus_a == 8'h00, "R10 shifts ignored during release", 32'(bus_a), 0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    #1 chk(bus_a == 8'h01, "R10 first shift after release", 32'(bus_a), 32'h01);

    // R8 bit order
    load_word(8'hC5);
    chk(link == 1'b1, "R8 first bit reaches ser_out", 32'(link), 1);
    step(1'b0, 1'b0, 1'b1);
    #1 chk(bus_a == 8'hC5, "R8 word order on par_q", 32'(bus_a), 32'hC5);

    // R5 output enable, R2 serial output unaffected
    @(negedge clk); oe_n = 1'b1; #1;
    chk(bus_a == 8'hFF, "R5 bus floats with oe_n high", 32'(bus_a), 32'hFF);
    chk(link == 1'b1, "R2 ser_out driven with oe_n high", 32'(link), 1);
    @(negedge clk); oe_n = 1'b0; #1;
    chk(bus_a == 8'hC5, "R5 bus driven with oe_n low", 32'(bus_a), 32'hC5);

    // R6 hold without shift strobe
    for (int i = 0; i < 5; i++) step(1'b0, i[0], 1'b0);
    step(1'b0, 1'b0, 1'b1);
    #1 chk(bus_a == 8'hC5, "R6 stages held without shift_en", 32'(bus_a), 32'hC5);

    // R3 storage hold and load
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
    #1 chk(bus_a == 8'hC5, "R3 storage held without latch_en", 32'(bus_a), 32'hC5);
    step(1'b0, 1'b0, 1'b1);
    #1 chk(bus_a == 8'h28, "R3 storage loads on latch_en", 32'(bus_a), 32'h28);

    // R4 asynchronous clear mid-cycle, storage kept
    load_word(8'h80);
    step(1'b0, 1'b0, 1'b1);
    @(negedge clk); #1;
    rst_n = 1'b0;
    #1;
    chk(link == 1'b0, "R4 clear without clock edge", 32'(link), 0);
    chk(bus_a == 8'h80, "R4 storage untouched by clear", 32'(bus_a), 32'h80);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 exp_sr = '0;
    chk(bus_a == 8'h80, "R4 storage kept after release", 32'(bus_a), 32'h80);
    step(1'b0, 1'b0, 1'b1);
    #1 chk(bus_a == 8'h00, "R4 storage cleared only by latch", 32'(bus_a), 0);

    // R7 same-edge shift and transfer
    load_word(8'h5A);
    step(1'b1, 1'b1, 1'b1);
    #1 chk(bus_a == 8'h5A, "R7 storage takes pre-shift contents", 32'(bus_a), 32'h5A);
    step(1'b0, 1'b0, 1'b1);
    #1 chk(bus_a == 8'hB5, "R7 shifted contents on next latch", 32'(bus_a), 32'hB5);

    // R9 two chained units
    chain_w = 16'hA53C;
    for (int i = 15; i >= 0; i--) step(1'b1, chain_w[i], 1'b0);
    step(1'b0, 1'b0, 1'b1);
    #1;
    chk(bus_a == 8'h3C, "R9 near unit holds last bits", 32'(bus_a), 32'h3C);
    chk(bus_b == 8'hA5, "R9 far unit holds first bits", 32'(bus_b), 32'hA5);

    // Random phase: R1 R2 R3 R5 against the bench model
    for (int n = 0; n < 400; n++) begin
      logic sh, si, la, oe;
      sh = 1'($urandom); si = 1'($urandom); la = 1'($urandom % 3 == 0); oe = 1'($urandom % 4 == 0);
      @(negedge clk); oe_n = oe;
      step(sh, si, la);
      #1;
      chk(link == exp_sr[D-1], "R1 R2 random ser_out", 32'(link), 32'(exp_sr[D-1]));
      chk(bus_a == bus_exp(oe_n, exp_st), "R3 R5 random par_q", 32'(bus_a), 32'(bus_exp(oe_n, exp_st)));
    end

    finish_run();
  end
endmodule